// File: doc/BRIEF.md
# Byte-Packing Command and Data Queue for a Two-Wire Bus Master

This block sits between a 32-bit register port and a two-wire bus sequencer. Software writes command words into a command FIFO and transmit data into a data FIFO as 32-bit words. It reads received data back as 32-bit words. The block unpacks transmit words into a byte stream for the sequencer. It packs the bytes the sequencer receives back into words. All bus timing belongs to the sequencer.

A run bit gates command dispatch. While run is set, the head command is offered to the sequencer, which takes one word at a time. A write command (bit 16 set) loads a byte budget from bits 15:0. The transmit stream then yields exactly that many bytes, and the unused high bytes of a short final word are discarded. A status word gives the pending command count, the empty state of the read queue, and a sticky overflow flag.

Top module: `i2cq_pio_queue`

## Requirements
- R1: After reset the status word (offset 0x70) reads 0x00002000, the control word (offset 0x60) reads 0, and neither cmd_valid_o nor tx_avail_o is asserted.
- R2: Control word bit 5 is run and bit 2 is queue mode. cmd_valid_o is high only while run is set and a command is pending. cmd_word_o shows the oldest pending command, and commands leave in write order, one per cycle with both cmd_valid_o and cmd_take_i high.
- R3: Status bits 4:0 give the number of pending command entries. A write to offset 0x80 adds an entry, and a dispatched command removes one.
- R4: In queue mode the command FIFO holds 16 entries. A command write while 16 are pending is dropped and sets status bit 15. Bit 15 stays set until a write to offset 0x70 with bit 15 set clears it.
- R5: With queue mode clear, commands bypass the FIFO through a single holding entry. A command write while one entry is pending is dropped and sets status bit 15.
- R6: Transmit words written at offset 0xA0 are sent least significant byte first. Bits 7:0 go first, then 15:8, 23:16 and 31:24.
- R7: A dispatched command with bit 16 set loads a byte budget from its bits 15:0. tx_avail_o falls once the budget is spent, and the rest of a partly used word is discarded. The next command's bytes then start with a fresh word.
- R8: Received bytes are packed least significant byte first. Each read at offset 0x90 with reg_rd_i returns the oldest packed word and removes it, and returns 0 when the read queue is empty.
- R9: When cmd_done_i is asserted, a partly filled receive word is queued at once with zero in its unused upper bytes. A word that is already full produces no extra word.
- R10: Status bit 13 is set exactly when the read queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops read data at 0x90) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| cmd_valid_o | output | 1 | Command word offered to the sequencer |
| cmd_word_o | output | 32 | Offered command word |
| cmd_take_i | input | 1 | Sequencer accepts the offered command |
| tx_byte_o | output | 8 | Next transmit byte |
| tx_avail_o | output | 1 | Transmit byte valid |
| tx_take_i | input | 1 | Sequencer consumes the transmit byte |
| rx_byte_i | input | 8 | Received byte |
| rx_push_i | input | 1 | Received byte strobe |
| cmd_done_i | input | 1 | Current command finished; flush partial receive word |

## Verification
The bench fills the command queue past 16 entries. A design that wrapped its count or accepted the extra word would show a wrong fill count, or would not raise the overflow flag. It repeats this in bypass mode, where a design that still used all 16 entries would accept the second word. A transmit budget of six bytes ends halfway through a word. A design that sent the leftover bytes would push the next command's first byte out of position. The bench also flushes a five-byte receive burst, and it ends a four-byte burst with done and the last byte in the same cycle. A design that zeroed the upper bytes incorrectly, or queued an empty extra word, would return read data that differs from the model.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam logic [7:0] OFF_QCTRL = 8'h60;
  localparam logic [7:0] OFF_QSTAT = 8'h70;
  localparam logic [7:0] OFF_CMD   = 8'h80;
  localparam logic [7:0] OFF_RXD   = 8'h90;
  localparam logic [7:0] OFF_TXD   = 8'hA0;

  localparam int QC_RUN     = 5;
  localparam int QC_QMODE   = 2;
  localparam int ST_CNT_W   = 5;
  localparam int ST_RXEMPTY = 13;
  localparam int ST_OVF     = 15;
  localparam int CMD_DIR    = 16;
  localparam int CMD_CNT_W  = 16;

  typedef struct packed {
    logic run;
    logic qmode;
  } qctrl_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop, empty;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_cnt_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> (count_o == $past(count_o) + CW'(1)));

  p_full_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_o == $past(count_o)));
endmodule

// File: rtl/i2cq_tx_unpack.sv
module i2cq_tx_unpack #(
  parameter int DW   = 32,
  parameter int CNTW = 16,
  localparam int NB  = DW / 8,
  localparam int IW  = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   word_i,
  input  logic            word_avail_i,
  output logic            word_pop_o,
  input  logic            cmd_load_i,
  input  logic [CNTW-1:0] cmd_count_i,
  input  logic            take_i,
  output logic [7:0]      byte_o,
  output logic            avail_o
);
  logic [DW-1:0]   word_q;
  logic            vld_q;
  logic [IW-1:0]   idx_q;
  logic [CNTW-1:0] rem_q;
  logic            take, last;

  assign word_pop_o = !vld_q && word_avail_i;
  assign avail_o    = vld_q && (rem_q != '0);
  assign take       = take_i && avail_o;
  // word retires on its top byte or when the budget runs out
  assign last       = (idx_q == IW'(NB - 1)) || (rem_q == CNTW'(1));
  assign byte_o     = word_q[int'(idx_q)*8 +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
    end else if (word_pop_o) begin
      word_q <= word_i;
      vld_q  <= 1'b1;
      idx_q  <= '0;
    end else if (take) begin
      if (last) begin
        vld_q <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rem_q <= '0;
    else if (cmd_load_i) rem_q <= cmd_count_i;
    else if (take)       rem_q <= rem_q - 1'b1;
  end

  p_budget_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !cmd_load_i) |=> (rem_q == $past(rem_q) - CNTW'(1)));

  p_budget_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && rem_q == CNTW'(1) && !cmd_load_i) |=> !avail_o);
endmodule

// File: rtl/i2cq_rx_pack.sv
module i2cq_rx_pack #(
  parameter int DW  = 32,
  localparam int NB = DW / 8,
  localparam int FW = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    byte_i,
  input  logic          push_i,
  input  logic          done_i,
  output logic [DW-1:0] word_o,
  output logic          word_vld_o
);
  logic [DW-1:0] acc_q, acc_n;
  logic [FW-1:0] fill_q, fill_n;

  always_comb begin
    acc_n  = acc_q;
    fill_n = fill_q;
    if (push_i) begin
      acc_n[int'(fill_q)*8 +: 8] = byte_i;
      fill_n = fill_q + 1'b1;
    end
  end

  assign word_vld_o = (fill_n == FW'(NB)) || (done_i && fill_n != '0);
  assign word_o     = acc_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (word_vld_o) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else begin
      acc_q  <= acc_n;
      fill_q <= fill_n;
    end
  end

  p_done_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && fill_q != '0) |=> (fill_q == '0));

  p_byte_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !done_i && fill_q < FW'(NB - 1)) |=> (fill_q == $past(fill_q) + FW'(1)));
endmodule

// File: rtl/i2cq_pio_queue.sv
module i2cq_pio_queue
  import i2cq_pkg::*;
#(
  parameter int DW        = 32,
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 8,
  localparam int CMD_CW   = $clog2(CMD_DEPTH + 1),
  localparam int TX_CW    = $clog2(TX_DEPTH + 1),
  localparam int RX_CW    = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [7:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_word_o,
  input  logic          cmd_take_i,
  output logic [7:0]    tx_byte_o,
  output logic          tx_avail_o,
  input  logic          tx_take_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          rx_push_i,
  input  logic          cmd_done_i
);
  qctrl_t ctrl_q;
  logic   ovf_q;

  logic wr_ctrl, wr_stat, wr_cmd, wr_txd, rd_rxd;
  assign wr_ctrl = reg_wr_i && (reg_addr_i == OFF_QCTRL);
  assign wr_stat = reg_wr_i && (reg_addr_i == OFF_QSTAT);
  assign wr_cmd  = reg_wr_i && (reg_addr_i == OFF_CMD);
  assign wr_txd  = reg_wr_i && (reg_addr_i == OFF_TXD);
  assign rd_rxd  = reg_rd_i && (reg_addr_i == OFF_RXD);

  // command path
  logic [CMD_CW-1:0] cmd_cnt;
  logic              cmd_full, cmd_cap_full, cmd_push, cmd_pop, cmd_load;

  // bypass mode = single holding entry in the same storage
  assign cmd_cap_full = ctrl_q.qmode ? cmd_full : (cmd_cnt != '0);
  assign cmd_push     = wr_cmd && !cmd_cap_full;
  assign cmd_valid_o  = ctrl_q.run && (cmd_cnt != '0);
  assign cmd_pop      = cmd_valid_o && cmd_take_i;
  assign cmd_load     = cmd_pop && cmd_word_o[CMD_DIR];

  i2cq_fifo #(.W(DW), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cmd_push),
    .wdata_i (reg_wdata_i),
    .pop_i   (cmd_pop),
    .rdata_o (cmd_word_o),
    .count_o (cmd_cnt),
    .full_o  (cmd_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run   <= reg_wdata_i[QC_RUN];
        ctrl_q.qmode <= reg_wdata_i[QC_QMODE];
      end
      if (wr_cmd && cmd_cap_full)          ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_OVF]) ovf_q <= 1'b0;
    end
  end

  // transmit path
  logic [DW-1:0]    tx_word;
  logic [TX_CW-1:0] tx_cnt;
  logic             tx_full, tx_pop;

  i2cq_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_txd && !tx_full),
    .wdata_i (reg_wdata_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_word),
    .count_o (tx_cnt),
    .full_o  (tx_full)
  );

  i2cq_tx_unpack #(.DW(DW), .CNTW(CMD_CNT_W)) u_tx_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_i       (tx_word),
    .word_avail_i (tx_cnt != '0),
    .word_pop_o   (tx_pop),
    .cmd_load_i   (cmd_load),
    .cmd_count_i  (cmd_word_o[CMD_CNT_W-1:0]),
    .take_i       (tx_take_i),
    .byte_o       (tx_byte_o),
    .avail_o      (tx_avail_o)
  );

  // receive path
  logic [DW-1:0]    rx_word, rx_head;
  logic             rx_word_vld, rx_full, rx_empty;
  logic [RX_CW-1:0] rx_cnt;

  i2cq_rx_pack #(.DW(DW)) u_rx_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (rx_byte_i),
    .push_i     (rx_push_i),
    .done_i     (cmd_done_i),
    .word_o     (rx_word),
    .word_vld_o (rx_word_vld)
  );

  i2cq_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_word_vld && !rx_full),
    .wdata_i (rx_word),
    .pop_i   (rd_rxd),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full)
  );

  assign rx_empty = (rx_cnt == '0);

  // register read mux
  logic [DW-1:0] stat_w, ctrl_w;
  always_comb begin
    stat_w = '0;
    stat_w[ST_CNT_W-1:0] = ST_CNT_W'(cmd_cnt);
    stat_w[ST_RXEMPTY]   = rx_empty;
    stat_w[ST_OVF]       = ovf_q;
    ctrl_w = '0;
    ctrl_w[QC_RUN]   = ctrl_q.run;
    ctrl_w[QC_QMODE] = ctrl_q.qmode;
  end

  always_comb begin
    case (reg_addr_i)
      OFF_QCTRL: reg_rdata_o = ctrl_w;
      OFF_QSTAT: reg_rdata_o = stat_w;
      OFF_RXD:   reg_rdata_o = rx_empty ? '0 : rx_head;
      default:   reg_rdata_o = '0;
    endcase
  end

  p_ovf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && cmd_cap_full) |=> ovf_q);

  p_ovf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_stat && reg_wdata_i[ST_OVF])) |=> ovf_q);

  p_bypass_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.qmode && cmd_cnt != '0 && !cmd_pop) |=> (cmd_cnt == $past(cmd_cnt)));

  p_dispatch_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_take_i && !ctrl_q.run && !wr_cmd) |=> (cmd_cnt == $past(cmd_cnt)));
endmodule

// File: tb/i2cq_pio_queue_bench.sv
`timescale 1ns/1ps
module i2cq_pio_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h70;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cmd_valid, cmd_take = 1'b0;
  logic [31:0] cmd_word;
  logic [7:0]  tx_byte, rx_byte = '0;
  logic        tx_avail, tx_take = 1'b0;
  logic        rx_push = 1'b0, cmd_done = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2cq_pio_queue u_i2cq_pio_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word), .cmd_take_i(cmd_take),
    .tx_byte_o(tx_byte), .tx_avail_o(tx_avail), .tx_take_i(tx_take),
    .rx_byte_i(rx_byte), .rx_push_i(rx_push), .cmd_done_i(cmd_done)
  );

  // behavioural reference model
  logic [31:0] m_cmdq[$], m_txq[$], m_rxq[$];
  logic        m_run = 0, m_qm = 0, m_ovf = 0, m_vld = 0;
  logic [31:0] m_cur = '0, m_acc = '0;
  int          m_idx = 0, m_rem = 0, m_fill = 0;
  logic [7:0]  got_tx[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    logic [31:0] v = '0;
    case (reg_addr)
      8'h60: begin v[5] = m_run; v[2] = m_qm; end
      8'h70: begin
        v[4:0] = 5'(m_cmdq.size());
        v[13]  = (m_rxq.size() == 0);
        v[15]  = m_ovf;
      end
      8'h90: v = (m_rxq.size() != 0) ? m_rxq[0] : '0;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic compare();
    string tg;
    tg = (reg_addr == 8'h90) ? "R8" : (reg_addr == 8'h60) ? "R2" : "R3";
    chk(tg, reg_rdata, m_rdata());
    chk("R2", {31'b0, cmd_valid}, {31'b0, m_run && m_cmdq.size() != 0});
    if (m_run && m_cmdq.size() != 0) chk("R2", cmd_word, m_cmdq[0]);
    chk("R7", {31'b0, tx_avail}, {31'b0, m_vld && m_rem != 0});
    if (m_vld && m_rem != 0) chk("R6", {24'b0, tx_byte}, {24'b0, m_cur[m_idx*8 +: 8]});
  endtask

  task automatic model_step();
    bit cap_full, fire, load, take, flush, tx_full, rx_full, rx_has;
    int rem0;
    logic [31:0] w;
    cap_full = m_qm ? (m_cmdq.size() >= 16) : (m_cmdq.size() >= 1);
    fire     = m_run && m_cmdq.size() != 0 && cmd_take;
    tx_full  = m_txq.size() >= 8;
    rx_full  = m_rxq.size() >= 8;
    rx_has   = m_rxq.size() != 0;
    load     = !m_vld && m_txq.size() != 0;
    take     = m_vld && m_rem != 0 && tx_take;
    rem0     = m_rem;
    if (fire) begin
      w = m_cmdq.pop_front();
      if (w[16]) m_rem = int'(w[15:0]);
      else if (take) m_rem = m_rem - 1;
    end else if (take) m_rem = m_rem - 1;
    if (reg_wr && reg_addr == 8'h80) begin
      if (cap_full) m_ovf = 1; else m_cmdq.push_back(reg_wdata);
    end else if (reg_wr && reg_addr == 8'h70 && reg_wdata[15]) m_ovf = 0;
    if (reg_wr && reg_addr == 8'h60) begin m_run = reg_wdata[5]; m_qm = reg_wdata[2]; end
    if (load) begin
      m_cur = m_txq.pop_front(); m_vld = 1; m_idx = 0;
    end else if (take) begin
      if (m_idx == 3 || rem0 == 1) begin m_vld = 0; m_idx = 0; end
      else m_idx++;
    end
    if (reg_wr && reg_addr == 8'hA0 && !tx_full) m_txq.push_back(reg_wdata);
    if (rx_push) begin m_acc[m_fill*8 +: 8] = rx_byte; m_fill++; end
    flush = (m_fill == 4) || (cmd_done && m_fill != 0);
    if (reg_rd && reg_addr == 8'h90 && rx_has) void'(m_rxq.pop_front());
    if (flush) begin
      if (!rx_full) m_rxq.push_back(m_acc);
      m_acc = '0; m_fill = 0;
    end
  endtask

  task automatic tick();
    #1;
    compare();
    if (tx_avail && tx_take) got_tx.push_back(tx_byte);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0; reg_addr = 8'h70; reg_wdata = '0;
  endtask

  task automatic rd_rx(output logic [31:0] v);
    reg_rd = 1; reg_addr = 8'h90;
    #1 v = reg_rdata;
    tick();
    reg_rd = 0; reg_addr = 8'h70;
  endtask

  task automatic rxb(logic [7:0] b, logic done);
    rx_push = 1; rx_byte = b; cmd_done = done;
    tick();
    rx_push = 0; cmd_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] exp_tx [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hAA, 8'hBB, 8'hC1, 8'hC2};
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", reg_rdata, 32'h0000_2000);
    chk("R1", {30'b0, cmd_valid, tx_avail}, 32'h0);
    reg_addr = 8'h60; #1 chk("R1", reg_rdata, 32'h0);
    reg_addr = 8'h70;
    tick();

    // R2 gate by run, queue mode
    wr(8'h60, 32'h04);
    wr(8'h80, 32'h0000_0007);
    wr(8'h80, 32'h0000_0009);
    #1 chk("R2", {31'b0, cmd_valid}, 32'h0);
    chk("R3", {27'b0, reg_rdata[4:0]}, 32'd2);
    wr(8'h60, 32'h24);
    #1 chk("R2", cmd_word, 32'h7);
    cmd_take = 1; tick(); tick(); cmd_take = 0;
    tick();
    chk("R3", {27'b0, reg_rdata[4:0]}, 32'd0);

    // R4 overflow at 16 entries
    wr(8'h60, 32'h04);
    for (int i = 0; i < 17; i++) wr(8'h80, 32'h100 + i);
    #1 chk("R4", {27'b0, reg_rdata[4:0]}, 32'd16);
    chk("R4", {31'b0, reg_rdata[15]}, 32'd1);
    tick();
    chk("R4", {31'b0, reg_rdata[15]}, 32'd1);
    wr(8'h70, 32'h8000);
    #1 chk("R4", {31'b0, reg_rdata[15]}, 32'd0);
    wr(8'h60, 32'h24);
    cmd_take = 1; repeat (17) tick(); cmd_take = 0;

    // R5 bypass single entry
    wr(8'h60, 32'h00);
    wr(8'h80, 32'hA5);
    wr(8'h80, 32'hA6);
    #1 chk("R5", {27'b0, reg_rdata[4:0]}, 32'd1);
    chk("R5", {31'b0, reg_rdata[15]}, 32'd1);
    wr(8'h70, 32'h8000);
    wr(8'h60, 32'h20);
    #1 chk("R5", cmd_word, 32'hA5);
    cmd_take = 1; tick(); cmd_take = 0;

    // R6/R7 byte order and budget
    wr(8'h60, 32'h24);
    wr(8'hA0, 32'h4433_2211);
    wr(8'hA0, 32'hDDCC_BBAA);
    wr(8'hA0, 32'h0000_C2C1);
    wr(8'h80, 32'h0001_0006);
    cmd_take = 1; tick(); cmd_take = 0;
    tx_take = 1; repeat (12) tick(); tx_take = 0;
    wr(8'h80, 32'h0001_0002);
    cmd_take = 1; tick(); cmd_take = 0;
    tx_take = 1; repeat (6) tick(); tx_take = 0;
    chk("R7", got_tx.size(), 8);
    for (int i = 0; i < 8; i++)
      if (i < got_tx.size()) chk((i < 4) ? "R6" : "R7", {24'b0, got_tx[i]}, {24'b0, exp_tx[i]});

    // R8/R9/R10 receive packing
    #1 chk("R10", {31'b0, reg_rdata[13]}, 32'd1);
    rxb(8'h11, 0); rxb(8'h22, 0); rxb(8'h33, 0); rxb(8'h44, 0); rxb(8'h55, 0);
    tick();
    cmd_done = 1; tick(); cmd_done = 0;
    rxb(8'h66, 0); rxb(8'h77, 0); rxb(8'h88, 0); rxb(8'h99, 1);
    tick();
    chk("R10", {31'b0, reg_rdata[13]}, 32'd0);
    rd_rx(v); chk("R8", v, 32'h4433_2211);
    rd_rx(v); chk("R9", v, 32'h0000_0055);
    rd_rx(v); chk("R9", v, 32'h9988_7766);
    #1 chk("R10", {31'b0, reg_rdata[13]}, 32'd1);
    rd_rx(v); chk("R8", v, 32'h0);
    repeat (3) tick();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule